// File: doc/BRIEF.md
# Multi-Mode Three-Comparator Symbol Decision Stage

This block turns the raw outputs of three threshold comparators into decided receive data. The comparators sit at three voltage levels and all fire once per received symbol. A symbol strobe marks each sample. The comparator results arrive on `smp_i`, where bit 0 is the comparator at the lowest threshold, bit 1 the centre one and bit 2 the highest.

The same three results are interpreted in one of three run-time modes.
- **Binary.** The centre comparator alone gives the bit.
- **Four-level.** All three comparators form a thermometer code, which is reduced to a Gray-coded 2-bit symbol. Each four-level symbol carries two bits at half the symbol rate that binary signalling needs for the same bit rate.
- **Speculative one-tap feedback.** The outer two comparators sit at plus and minus the expected first post-cursor residual interference. The bit decided for the previous symbol picks which of the two results becomes the new bit. No correction is applied to the signal itself.

A requested mode change is taken only when a symbol strobe arrives. The symbol at which the change happens is discarded.

Top module: `pam_slicer_top`

## Requirements
- R1: While `rst_n` is low, and until the first strobed symbol, `vld_o`, `err_o` and `sym_o` are 0. The active mode after reset is binary. The feedback history after reset is 0.
- R2: `vld_o` is high for exactly the one clock cycle that follows a clock edge at which `sym_vld_i` was high and no mode change was taken. Otherwise it is low.
- R3: In binary mode (`mode_i` = 2'b00), a decided symbol gives `sym_o` = {1'b0, `smp_i[1]`}. `smp_i[0]` and `smp_i[2]` have no effect.
- R4: In four-level mode (`mode_i` = 2'b01), thermometer patterns decode as follows: 3'b000 gives 2'b00, 3'b001 gives 2'b01, 3'b011 gives 2'b11, and 3'b111 gives 2'b10. `err_o` stays 0 for these patterns.
- R5: In four-level mode, any pattern that is not a thermometer code raises `err_o` together with `vld_o`. `sym_o` then carries the Gray code of the number of comparators that fired: 3'b010 and 3'b100 give 2'b01, and 3'b101 and 3'b110 give 2'b11.
- R6: `err_o` is never high unless `vld_o` is high and the active mode is four-level.
- R7: In feedback mode (`mode_i` = 2'b10), `sym_o` = {1'b0, b}. Here b is `smp_i[2]` (the +alpha comparator) when the history bit is 1, and `smp_i[0]` (the -alpha comparator) when it is 0. `smp_i[1]` has no effect.
- R8: The history bit takes each bit decided in feedback mode. It is cleared to 0 whenever a mode change is taken.
- R9: A new `mode_i` value is taken only at a strobed symbol. That symbol produces no valid output. A `mode_i` value that changes and returns between strobes causes no blanking.
- R10: `mode_i` = 2'b11 behaves as binary mode. Moving between 2'b11 and 2'b00 still counts as a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_vld_i | input | 1 | High for one cycle per sampled symbol |
| mode_i | input | 2 | Requested mode: 00 binary, 01 four-level, 10 feedback, 11 binary |
| smp_i | input | 3 | Comparator results, bit 0 lowest threshold, bit 2 highest |
| sym_o | output | 2 | Decided symbol, bit 1 is 0 outside four-level mode |
| vld_o | output | 1 | Decided symbol present this cycle |
| err_o | output | 1 | Four-level pattern was not a thermometer code |

## Verification
The properties assume that `sym_vld_i` and `mode_i` are held steady across each clock edge and low while reset is asserted. They relate each output only to the inputs sampled at the edge before it. The stimulus drives every input at the falling edge and raises the strobe for a single cycle per symbol. The mode only changes between symbols, except in the one directed case that toggles it without a strobe. The stimulus reaches every comparator pattern in four-level mode, and it reaches both history values in feedback mode with each outer comparator set both ways.

// File: rtl/pam_slicer_pkg.sv
package pam_slicer_pkg;

    localparam int SMP_N  = 3;
    localparam int MODE_W = 2;
    localparam int SYM_W  = 2;
    localparam int LVL_W  = $clog2(SMP_N + 1);

    localparam int IDX_LO  = 0;
    localparam int IDX_MID = 1;
    localparam int IDX_HI  = SMP_N - 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_NRZ    = 2'b00,
        MODE_PAM4   = 2'b01,
        MODE_UNROLL = 2'b10,
        MODE_SPARE  = 2'b11
    } slc_mode_e;

    typedef struct packed {
        slc_mode_e        mode;
        logic             hist;
        logic             vld;
        logic             err;
        logic [SYM_W-1:0] sym;
    } slc_state_t;

endpackage

// File: rtl/pam_thermo_decode.sv
module pam_thermo_decode
    import pam_slicer_pkg::*;
#(
    parameter int N = SMP_N
) (
    input  logic [N-1:0]     smp,
    output logic [SYM_W-1:0] gray,
    output logic             bad
);

    localparam int LW = $clog2(N + 1);

    logic [LW-1:0] level;
    logic [N-1:0]  ideal;

    // Count how many comparators fired.
    always_comb begin
        level = '0;
        for (int i = 0; i < N; i++) begin
            level = level + LW'(smp[i]);
        end
    end

    // The thermometer pattern that has the same number of ones.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ideal[i] = (LW'(i) < level);
        end
    end

    assign bad  = (smp != ideal);
    assign gray = {level[1], level[1] ^ level[0]};

endmodule

// File: rtl/pam_unroll_select.sv
module pam_unroll_select
    import pam_slicer_pkg::*;
#(
    parameter int N      = SMP_N,
    parameter int POS_IX = IDX_HI,
    parameter int NEG_IX = IDX_LO
) (
    input  logic [N-1:0] smp,
    input  logic         hist,
    output logic         bit_o
);

    // A previous one adds +alpha of interference, so the +alpha comparator is used.
    assign bit_o = hist ? smp[POS_IX] : smp[NEG_IX];

endmodule

// File: rtl/pam_slicer_top.sv
module pam_slicer_top
    import pam_slicer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_vld_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [SMP_N-1:0]  smp_i,
    output logic [SYM_W-1:0]  sym_o,
    output logic              vld_o,
    output logic              err_o
);

    slc_state_t state_d, state_q;

    logic [SYM_W-1:0] pam4_sym;
    logic             pam4_bad;
    logic             unroll_bit;

    pam_thermo_decode #(.N(SMP_N)) u_thermo (
        .smp  (smp_i),
        .gray (pam4_sym),
        .bad  (pam4_bad)
    );

    pam_unroll_select #(.N(SMP_N), .POS_IX(IDX_HI), .NEG_IX(IDX_LO)) u_unroll (
        .smp   (smp_i),
        .hist  (state_q.hist),
        .bit_o (unroll_bit)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        state_d.err = 1'b0;
        if (sym_vld_i) begin
            if (mode_i != state_q.mode) begin
                // Take the new mode at this boundary and discard the symbol.
                state_d.mode = slc_mode_e'(mode_i);
                state_d.hist = 1'b0;
                state_d.sym  = '0;
            end else begin
                state_d.vld = 1'b1;
                case (state_q.mode)
                    MODE_PAM4: begin
                        state_d.sym = pam4_sym;
                        state_d.err = pam4_bad;
                    end
                    MODE_UNROLL: begin
                        state_d.sym  = {1'b0, unroll_bit};
                        state_d.hist = unroll_bit;
                    end
                    default: begin
                        state_d.sym = {1'b0, smp_i[IDX_MID]};
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{mode: MODE_NRZ, hist: 1'b0, vld: 1'b0, err: 1'b0, sym: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign sym_o = state_q.sym;
    assign vld_o = state_q.vld;
    assign err_o = state_q.err;

endmodule

// File: rtl/pam_slicer_chk.sv
module pam_slicer_chk
    import pam_slicer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sym_vld_i,
    input logic [MODE_W-1:0] mode_i,
    input logic [SMP_N-1:0]  smp_i,
    input logic [SYM_W-1:0]  sym_o,
    input logic              vld_o,
    input logic              err_o,
    input logic [MODE_W-1:0] mode_act
);

    assert_vld_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(sym_vld_i));

    assert_blank_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld_i && mode_i != mode_act) |=> !vld_o);

    assert_err_only_pam4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (vld_o && mode_act == MODE_PAM4));

    assert_nrz_centre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(mode_i) == MODE_NRZ) |-> sym_o == {1'b0, $past(smp_i[IDX_MID])});

    assert_pam4_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(mode_i) == MODE_PAM4 && $past(smp_i) == 3'b111)
            |-> (sym_o == 2'b10 && !err_o));

    assert_msb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(mode_i) != MODE_PAM4) |-> !sym_o[1]);

endmodule

bind pam_slicer_top pam_slicer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_vld_i (sym_vld_i),
    .mode_i    (mode_i),
    .smp_i     (smp_i),
    .sym_o     (sym_o),
    .vld_o     (vld_o),
    .err_o     (err_o),
    .mode_act  (state_q.mode)
);

// File: tb/pam_slicer_top_tb.sv
`timescale 1ns/1ps
module pam_slicer_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_vld_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [2:0] smp_i = 3'b000;
    logic [1:0] sym_o;
    logic       vld_o;
    logic       err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pam_slicer_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_vld_i (sym_vld_i),
        .mode_i    (mode_i),
        .smp_i     (smp_i),
        .sym_o     (sym_o),
        .vld_o     (vld_o),
        .err_o     (err_o)
    );

    // Each entry: mode, comparators, expected symbol, expected valid, expected error.
    localparam int NV = 23;
    localparam logic [8:0] VEC [NV] = '{
        {2'b00, 3'b010, 2'b01, 1'b1, 1'b0},
        {2'b00, 3'b101, 2'b00, 1'b1, 1'b0},
        {2'b00, 3'b111, 2'b01, 1'b1, 1'b0},
        {2'b01, 3'b111, 2'b00, 1'b0, 1'b0},
        {2'b01, 3'b000, 2'b00, 1'b1, 1'b0},
        {2'b01, 3'b001, 2'b01, 1'b1, 1'b0},
        {2'b01, 3'b011, 2'b11, 1'b1, 1'b0},
        {2'b01, 3'b111, 2'b10, 1'b1, 1'b0},
        {2'b01, 3'b010, 2'b01, 1'b1, 1'b1},
        {2'b01, 3'b110, 2'b11, 1'b1, 1'b1},
        {2'b01, 3'b100, 2'b01, 1'b1, 1'b1},
        {2'b01, 3'b101, 2'b11, 1'b1, 1'b1},
        {2'b10, 3'b111, 2'b00, 1'b0, 1'b0},
        {2'b10, 3'b001, 2'b01, 1'b1, 1'b0},
        {2'b10, 3'b011, 2'b00, 1'b1, 1'b0},
        {2'b10, 3'b100, 2'b00, 1'b1, 1'b0},
        {2'b10, 3'b101, 2'b01, 1'b1, 1'b0},
        {2'b10, 3'b100, 2'b01, 1'b1, 1'b0},
        {2'b10, 3'b010, 2'b00, 1'b1, 1'b0},
        {2'b11, 3'b010, 2'b00, 1'b0, 1'b0},
        {2'b11, 3'b010, 2'b01, 1'b1, 1'b0},
        {2'b00, 3'b000, 2'b00, 1'b0, 1'b0},
        {2'b00, 3'b000, 2'b00, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one strobed symbol, then sample one ns after the edge that registers it.
    task automatic send(input logic [1:0] m, input logic [2:0] s);
        @(negedge clk);
        mode_i    = m;
        smp_i     = s;
        sym_vld_i = 1'b1;
        @(posedge clk);
        #1;
        sym_vld_i = 1'b0;
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic ev, input logic ee);
        if (!ev)           return "R9 blank";
        if (m == 2'b00)    return "R3 binary";
        if (m == 2'b11)    return "R10 spare";
        if (m == 2'b10)    return "R7 R8 feedback";
        if (ee)            return "R5 nonthermo";
        return "R4 thermo";
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(vld_o == 1'b0 && err_o == 1'b0 && sym_o == 2'b00, "R1 in reset",
              {sym_o, vld_o, err_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(vld_o == 1'b0, "R1 after release", vld_o, 0);

        // Main table: mode, comparators and expected results.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] m, es;
            logic [2:0] s;
            logic       ev, ee;
            {m, s, es, ev, ee} = VEC[i];
            send(m, s);
            check(vld_o == ev, tag_of(m, ev, ee), vld_o, ev);
            if (ev) begin
                check(sym_o == es, tag_of(m, ev, ee), sym_o, es);
            end
            check(err_o == ee, (m == 2'b01) ? "R5 flag" : "R6 flag", err_o, ee);
            @(posedge clk);
            #1;
            check(vld_o == 1'b0, "R2 one cycle", vld_o, 0);
        end

        // R9: a mode value that toggles between strobes does not blank.
        @(negedge clk);
        mode_i = 2'b01;
        repeat (3) @(negedge clk);
        mode_i = 2'b00;
        send(2'b00, 3'b010);
        check(vld_o == 1'b1 && sym_o == 2'b01, "R9 no strobe no change",
              {sym_o, vld_o}, 3);

        // R8: after reset the history is 0, so the -alpha comparator is used first.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send(2'b10, 3'b000);
        check(vld_o == 1'b0, "R9 entry blank", vld_o, 0);
        send(2'b10, 3'b100);
        check(vld_o == 1'b1 && sym_o == 2'b00, "R8 history zero", {sym_o, vld_o}, 1);
        send(2'b10, 3'b001);
        check(sym_o == 2'b01, "R7 low comparator", sym_o, 1);
        send(2'b10, 3'b100);
        check(sym_o == 2'b01, "R8 history one", sym_o, 1);

        // R8: leaving and re-entering feedback mode clears the history.
        send(2'b00, 3'b000);
        send(2'b10, 3'b000);
        send(2'b10, 3'b100);
        check(vld_o == 1'b1 && sym_o == 2'b00, "R8 cleared on change", {sym_o, vld_o}, 1);

        // R2: no output without a strobe.
        repeat (2) @(posedge clk);
        #1;
        check(vld_o == 1'b0 && err_o == 1'b0, "R2 idle", {vld_o, err_o}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule